// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two N-bit two's-complement numbers and returns their full 2N-bit signed product. It works serially: a pulse on `start` captures both operands and clears an internal running sum. The block then visits one bit of the second operand per clock, starting at the least significant bit. For each bit that is set, it adds a copy of the first operand that has been sign-extended to 2N bits and shifted to the bit's weight. The running sum sits in a register, so the logic between clock edges is a single 2N-bit adder rather than a chain of them.

The top bit of a two's-complement multiplier carries a negative weight. At that final step the block therefore subtracts the shifted copy instead of adding it. Negative operands are multiplied directly, with no conversion to magnitudes and no sign fix-up afterwards. Carries out of bit 2N-1 are dropped at every step. A multiplication takes N cycles. The result stays on `product` until the next multiplication completes.

Top module: `seq_signed_mul`

## Requirements
- R1: While reset is held and after it is released, `busy` is 0, `done` is 0 and `product` is 0.
- R2: When `start` is sampled high with `busy` low, `a` and `b` are captured at that edge. `busy` reads 1 from the following cycle for exactly N cycles.
- R3: `done` is 1 for exactly one cycle, the N-th cycle after the accepting edge. `busy` is 0 in that cycle.
- R4: In the `done` cycle, `product` equals the signed product of the captured `a` and `b`, as a 2N-bit two's-complement value. This holds for every operand pair, including the most negative value times itself (for N=4, 1000 × 1000 = 01000000).
- R5: For N=4, operands 1011 and 1101 (-5 and -3) yield 00001111 (+15).
- R6: A `start` sampled while `busy` is 1 is ignored. The operation in progress keeps its operands and its timing.
- R7: `product` changes only in a `done` cycle. Outside it, `product` holds its value regardless of `a`, `b` and `start`.
- R8: A `start` sampled in the `done` cycle is accepted, so operations can run back to back without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier, two's complement |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Signed product of the last completed operation |

## Verification
Counting from the rising edge that samples `start`, `busy` is due one cycle later and `done` plus the new `product` are due N cycles later. `done` falls again one cycle after that. The bench drives inputs on falling edges and samples each output on the falling edge that follows the clock edge at which the output is due. It checks `busy` at each intermediate cycle, and checks `done` and `product` at exactly the N-th cycle. The ignored-start, back-to-back and hold cases use the same counting, so an early or late result is reported as a failure.

// File: rtl/seq_signed_mul.sv
module seq_signed_mul #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int W  = 2 * N;
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [W-1:0]  mc;
  logic [N-1:0]  mp;
  logic [W-1:0]  acc;
  logic [CW-1:0] cnt;
  logic [W-1:0]  addend, term, sum;
  logic          last;

  assign last   = (cnt == LAST);
  assign addend = mp[0] ? mc : '0;
  assign term   = last ? (~addend + W'(1)) : addend;
  assign sum    = acc + term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc      <= '0;
      mp      <= '0;
      acc     <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= sum;
        mc  <= mc << 1;
        mp  <= mp >> 1;
        cnt <= cnt + CW'(1);
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= sum;
        end
      end else if (start) begin
        mc   <= {{N{a[N-1]}}, a};
        mp   <= b;
        acc  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end
    end
  end

  p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_busy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);

  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && cnt == $past(cnt) + CW'(1)));

  p_product_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tb_seq_signed_mul.sv
module tb_seq_signed_mul;
  localparam int N = 4;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic busy, done;
  logic [W-1:0] product;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  seq_signed_mul #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .busy(busy), .done(done), .product(product)
  );

  // {a, b, expected product}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {4'b1011, 4'b1101, 8'h0F},
    {4'h8,    4'h8,    8'h40},
    {4'h7,    4'h7,    8'h31},
    {4'h7,    4'h8,    8'hC8},
    {4'h0,    4'h9,    8'h00},
    {4'hF,    4'hF,    8'h01},
    {4'h1,    4'hF,    8'hFF},
    {4'h5,    4'h3,    8'h0F}
  };

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    int px, py;
    px = int'($signed(x));
    py = int'($signed(y));
    return W'(px * py);
  endfunction

  // Drives start on a negedge, then checks busy/done timing and the result.
  task automatic run(input logic [N-1:0] x, input logic [N-1:0] y,
                     input logic [W-1:0] exp, input string req, input bit full);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (full) chk(busy === 1'b1 && done === 1'b0, "R2", {7'b0, busy}, 8'h01);
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      if (full) chk(busy === 1'b1 && done === 1'b0, "R2", {6'b0, busy, done}, 8'h02);
    end
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R3", {6'b0, busy, done}, 8'h01);
    chk(product === exp, req, product, exp);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] keep;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1", product, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1", product, 8'h00);

    // R5 example and table vectors, with full timing checks (R2, R3, R4)
    run(4'b1011, 4'b1101, 8'h0F, "R5", 1'b1);
    @(negedge clk);
    chk(done === 1'b0, "R3", {7'b0, done}, 8'h00);
    for (int v = 0; v < NV; v++) begin
      run(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0], "R4", 1'b1);
      @(negedge clk);
    end

    // R4 exhaustive against the signed reference
    for (int x = 0; x < (1 << N); x++)
      for (int y = 0; y < (1 << N); y++) begin
        run(N'(x), N'(y), ref_mul(N'(x), N'(y)), "R4", 1'b0);
        @(negedge clk);
      end

    // R6: start while busy is ignored
    a = 4'h3; b = 4'h5; start = 1'b1;
    @(negedge clk);
    a = 4'h8; b = 4'h8;
    @(negedge clk);
    chk(busy === 1'b1, "R6", {7'b0, busy}, 8'h01);
    for (int i = 2; i < N; i++) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b1, "R6", {7'b0, done}, 8'h01);
    chk(product === 8'h0F, "R6", product, 8'h0F);

    // R8: start in the done cycle is accepted (back to back)
    run(4'h6, 4'hD, ref_mul(4'h6, 4'hD), "R8", 1'b1);
    run(4'hA, 4'h9, ref_mul(4'hA, 4'h9), "R8", 1'b1);

    // R7: product holds while idle with changing inputs
    keep = product;
    for (int i = 0; i < 6; i++) begin
      a = N'(i * 3); b = N'(i * 5 + 1);
      @(negedge clk);
      chk(product === keep && busy === 1'b0, "R7", product, keep);
    end

    // R7: product holds during a busy phase
    a = 4'h2; b = 4'h2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      chk(product === keep, "R7", product, keep);
    end
    @(negedge clk);
    chk(product === 8'h04, "R4", product, 8'h04);

    // R1: reset in mid-operation clears the outputs
    a = 4'h7; b = 4'h7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1", product, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule